// File: doc/BRIEF.md
# Cache ECC Error Injection Controller

This block lets software plant deliberate bit errors in the tag or data arrays of a cache. The purpose is to exercise the ECC detection and correction paths. Software programs three 64-bit registers over a simple register bus:

- a control word;
- a delay counter;
- a flip mask.

Once the control word enables injection, the block either arms at once or first counts the delay down to zero, one step per clock. When it is armed, the next cache access produces an inject strobe. The strobe carries a tag/data target select, a per-bank enable vector and an XOR mask.

The cache side acknowledges a strobe when the corruption was actually applied. After an acknowledged injection the block does one of two things, chosen by the persist setting:

- it disables itself, for a one-shot injection;
- it reloads the delay with the last value software wrote and arms again.

An unacknowledged strobe leaves the block armed. The SRAM arrays and the ECC encoder and decoder are outside this block.

Top module: `ecc_inject_ctrl`

## Requirements
- R1: After reset, the control, delay and mask registers all read 0 and `inj_valid` stays 0, even while `acc_valid` is high.
- R2: Register words are selected by `addr[6:3]` in a 128-byte window.
  - Word 0 is control, word 1 is delay and word 2 is mask. Every other word reads 0 and ignores writes.
  - Control bits: bit 0 = enable, bit 1 = persist, bit 2 = delay-enable, bit 3 = target (0 tag, 1 data), bits 4 and up = bank field (NUM_BANKS bits).
  - Control bits outside these fields read 0.
- R3: With enable=1 and delay-enable=0, `inj_valid` is high in the same cycle as `acc_valid`.
- R4: With enable=1 and delay-enable=1, the delay register decrements by one per clock until it reaches 0 and reads back its live value. `inj_valid` stays 0 while the count is non-zero and follows `acc_valid` once it is 0.
- R5: An acknowledged injection (`inj_valid` and `inj_ack` in the same cycle) with persist=0 clears the enable bit, and no further strobe follows.
- R6: An acknowledged injection with persist=1 keeps the enable bit set and reloads the delay counter with the last value written to the delay register.
- R7: `inj_target` equals the target bit. For a data target, `inj_mask` equals the mask register. For a tag target, `inj_mask` keeps only the low TAG_W mask bits and the rest are 0.
- R8: `inj_bank` equals the bank field of the control register whenever `inj_valid` is high.
- R9: A strobe without `inj_ack` leaves the block armed. The next access strobes again and the counter does not reload.
- R10: A write to the delay register during a countdown replaces both the live count and the reload value, and the countdown continues from the new value.
- R11: With enable=0, `inj_valid` stays 0 for any access. While `inj_valid` is 0, `inj_target`, `inj_bank` and `inj_mask` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_waddr | input | ADDR_W | Write byte address within the window |
| reg_wdata | input | 64 | Write data |
| reg_raddr | input | ADDR_W | Read byte address within the window |
| reg_rdata | output | 64 | Read data for `reg_raddr`, combinational |
| acc_valid | input | 1 | A cache access is taking place this cycle |
| inj_ack | input | 1 | The cache applied the strobed injection |
| inj_valid | output | 1 | Inject strobe |
| inj_target | output | 1 | 0 = tag array, 1 = data array |
| inj_bank | output | NUM_BANKS | Banks the mask applies to |
| inj_mask | output | 64 | XOR mask for the stored bits |

## Verification
The strobe and read data are combinational, so each result belongs to the state held before the next clock edge. A register write, a countdown step, a reload or an enable clear shows up one edge later. The bench drives inputs at the falling edge and checks the outputs one time unit later, before the rising edge. Each table row's expected values therefore describe the state left by the previous rows. A delay of N reaches zero exactly N edges after the enabling control write, and the table checks the counter value at each of those cycles.

// File: rtl/eci_pkg.sv
package eci_pkg;

    localparam int unsigned REG_W = 64;

    // control bit positions (software visible)
    localparam int unsigned BIT_EN    = 0;
    localparam int unsigned BIT_PERS  = 1;
    localparam int unsigned BIT_DLYEN = 2;
    localparam int unsigned BIT_TGT   = 3;
    localparam int unsigned BANK_LSB  = 4;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_DELAY = 2'd1,
        SEL_MASK  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic tgt;
        logic dly_en;
        logic pers;
        logic en;
    } ctrl_flags_t;

    function automatic reg_sel_e sel_of(input int unsigned word_idx);
        case (word_idx)
            0:       return SEL_CTRL;
            1:       return SEL_DELAY;
            2:       return SEL_MASK;
            default: return SEL_NONE;
        endcase
    endfunction

    // keep the low keep_w bits of a mask, zero the rest
    function automatic logic [REG_W-1:0] trim_low(input logic [REG_W-1:0] m,
                                                  input int unsigned keep_w);
        logic [REG_W-1:0] r;
        for (int i = 0; i < REG_W; i++) begin
            r[i] = (i < keep_w) ? m[i] : 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/eci_regfile.sv
module eci_regfile
    import eci_pkg::*;
#(
    parameter int unsigned ADDR_W    = 7,
    parameter int unsigned NUM_BANKS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    waddr,
    input  logic [REG_W-1:0]     wdata,
    input  logic [ADDR_W-1:0]    raddr,
    input  logic                 consume,
    input  logic [REG_W-1:0]     live_count,
    output ctrl_flags_t          flags,
    output logic [NUM_BANKS-1:0] bank_en,
    output logic [REG_W-1:0]     flip_mask,
    output logic                 dly_load,
    output logic [REG_W-1:0]     rdata
);
    localparam int unsigned WORD_LSB = 3;
    localparam int unsigned WORD_W   = ADDR_W - WORD_LSB;

    reg_sel_e wsel, rsel;
    logic     ctrl_wr, mask_wr;

    assign wsel     = sel_of(int'(waddr[ADDR_W-1:WORD_LSB]));
    assign rsel     = sel_of(int'(raddr[ADDR_W-1:WORD_LSB]));
    assign ctrl_wr  = wr_en && (wsel == SEL_CTRL);
    assign mask_wr  = wr_en && (wsel == SEL_MASK);
    assign dly_load = wr_en && (wsel == SEL_DELAY);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags     <= '0;
            bank_en   <= '0;
            flip_mask <= '0;
        end else begin
            if (ctrl_wr) begin
                flags.en     <= wdata[BIT_EN];
                flags.pers   <= wdata[BIT_PERS];
                flags.dly_en <= wdata[BIT_DLYEN];
                flags.tgt    <= wdata[BIT_TGT];
                bank_en      <= wdata[BANK_LSB +: NUM_BANKS];
            end else if (consume && !flags.pers) begin
                flags.en <= 1'b0;
            end
            if (mask_wr) begin
                flip_mask <= wdata;
            end
        end
    end

    logic [REG_W-1:0] ctrl_view;
    always_comb begin
        ctrl_view                        = '0;
        ctrl_view[BIT_EN]                = flags.en;
        ctrl_view[BIT_PERS]              = flags.pers;
        ctrl_view[BIT_DLYEN]             = flags.dly_en;
        ctrl_view[BIT_TGT]               = flags.tgt;
        ctrl_view[BANK_LSB +: NUM_BANKS] = bank_en;
    end

    always_comb begin
        case (rsel)
            SEL_CTRL:  rdata = ctrl_view;
            SEL_DELAY: rdata = live_count;
            SEL_MASK:  rdata = flip_mask;
            default:   rdata = '0;
        endcase
    end

    logic unused_ok;
    assign unused_ok = ^{WORD_W[0]};
endmodule

// File: rtl/eci_delay.sv
module eci_delay
    import eci_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [REG_W-1:0] load_val,
    input  logic             run,
    input  logic             rearm,
    output logic [REG_W-1:0] count,
    output logic [REG_W-1:0] reload_val,
    output logic             at_zero
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count      <= '0;
            reload_val <= '0;
        end else if (load) begin
            count      <= load_val;
            reload_val <= load_val;
        end else if (rearm) begin
            count <= reload_val;
        end else if (run && (count != '0)) begin
            count <= count - 1'b1;
        end
    end

    assign at_zero = (count == '0);
endmodule

// File: rtl/eci_arm.sv
module eci_arm
    import eci_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 8,
    parameter int unsigned TAG_W     = 24
) (
    input  ctrl_flags_t          flags,
    input  logic [NUM_BANKS-1:0] bank_en,
    input  logic [REG_W-1:0]     flip_mask,
    input  logic                 at_zero,
    input  logic                 acc_valid,
    input  logic                 inj_ack,
    output logic                 strobe,
    output logic                 consume,
    output logic                 tgt_o,
    output logic [NUM_BANKS-1:0] bank_o,
    output logic [REG_W-1:0]     mask_o
);
    logic             armed;
    logic [REG_W-1:0] shaped;

    assign armed   = flags.en && (!flags.dly_en || at_zero);
    assign strobe  = armed && acc_valid;
    assign consume = strobe && inj_ack;
    assign shaped  = flags.tgt ? flip_mask : trim_low(flip_mask, TAG_W);

    assign tgt_o  = strobe ? flags.tgt : 1'b0;
    assign bank_o = strobe ? bank_en   : '0;
    assign mask_o = strobe ? shaped    : '0;
endmodule

// File: rtl/ecc_inject_ctrl.sv
module ecc_inject_ctrl
    import eci_pkg::*;
#(
    parameter int unsigned ADDR_W    = 7,
    parameter int unsigned NUM_BANKS = 8,
    parameter int unsigned TAG_W     = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr_en,
    input  logic [ADDR_W-1:0]    reg_waddr,
    input  logic [63:0]          reg_wdata,
    input  logic [ADDR_W-1:0]    reg_raddr,
    output logic [63:0]          reg_rdata,
    input  logic                 acc_valid,
    input  logic                 inj_ack,
    output logic                 inj_valid,
    output logic                 inj_target,
    output logic [NUM_BANKS-1:0] inj_bank,
    output logic [63:0]          inj_mask
);
    ctrl_flags_t          flags;
    logic [NUM_BANKS-1:0] bank_en;
    logic [REG_W-1:0]     flip_mask;
    logic [REG_W-1:0]     count;
    logic [REG_W-1:0]     reload_val;
    logic                 dly_load, at_zero, consume;
    logic                 en_q, pers_q, dlyen_q;

    assign en_q    = flags.en;
    assign pers_q  = flags.pers;
    assign dlyen_q = flags.dly_en;

    eci_regfile #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr_en),
        .waddr     (reg_waddr),
        .wdata     (reg_wdata),
        .raddr     (reg_raddr),
        .consume   (consume),
        .live_count(count),
        .flags     (flags),
        .bank_en   (bank_en),
        .flip_mask (flip_mask),
        .dly_load  (dly_load),
        .rdata     (reg_rdata)
    );

    eci_delay u_delay (
        .clk       (clk),
        .rst       (rst),
        .load      (dly_load),
        .load_val  (reg_wdata),
        .run       (flags.en && flags.dly_en),
        .rearm     (consume && flags.pers),
        .count     (count),
        .reload_val(reload_val),
        .at_zero   (at_zero)
    );

    eci_arm #(.NUM_BANKS(NUM_BANKS), .TAG_W(TAG_W)) u_arm (
        .flags    (flags),
        .bank_en  (bank_en),
        .flip_mask(flip_mask),
        .at_zero  (at_zero),
        .acc_valid(acc_valid),
        .inj_ack  (inj_ack),
        .strobe   (inj_valid),
        .consume  (consume),
        .tgt_o    (inj_target),
        .bank_o   (inj_bank),
        .mask_o   (inj_mask)
    );
endmodule

// File: rtl/eci_checker.sv
module eci_checker #(
    parameter int unsigned ADDR_W    = 7,
    parameter int unsigned NUM_BANKS = 8,
    parameter int unsigned TAG_W     = 24
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 reg_wr_en,
    input logic [ADDR_W-1:0]    reg_waddr,
    input logic                 acc_valid,
    input logic                 inj_ack,
    input logic                 inj_valid,
    input logic                 inj_target,
    input logic [NUM_BANKS-1:0] inj_bank,
    input logic [63:0]          inj_mask,
    input logic                 en_q,
    input logic                 pers_q,
    input logic                 dlyen_q,
    input logic [63:0]          count,
    input logic [63:0]          reload_val
);
    logic wr_ctrl, wr_delay;
    assign wr_ctrl  = reg_wr_en && (reg_waddr[ADDR_W-1:3] == '0);
    assign wr_delay = reg_wr_en && (reg_waddr[ADDR_W-1:3] == 1);

    p_immediate_r3: assert property (@(posedge clk) disable iff (rst)
        en_q && !dlyen_q && acc_valid |-> inj_valid);

    p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
        en_q && dlyen_q && (count != 0) && !wr_delay && !(inj_valid && inj_ack)
        |=> count == $past(count) - 64'd1);

    p_hold_while_counting_r4: assert property (@(posedge clk) disable iff (rst)
        en_q && dlyen_q && (count != 0) |-> !inj_valid);

    p_one_shot_r5: assert property (@(posedge clk) disable iff (rst)
        inj_valid && inj_ack && !pers_q && !wr_ctrl |=> !en_q && !inj_valid);

    p_reload_r6: assert property (@(posedge clk) disable iff (rst)
        inj_valid && inj_ack && pers_q && !wr_delay && !wr_ctrl
        |=> en_q && count == $past(reload_val));

    p_tag_trim_r7: assert property (@(posedge clk) disable iff (rst)
        inj_valid && !inj_target |-> (inj_mask >> TAG_W) == 64'd0);

    p_stay_armed_r9: assert property (@(posedge clk) disable iff (rst)
        inj_valid && !inj_ack && !reg_wr_en |=> $stable(count) && en_q);

    p_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !inj_valid |-> !inj_target && inj_bank == '0 && inj_mask == 64'd0);

    p_disabled_r11: assert property (@(posedge clk) disable iff (rst)
        !en_q |-> !inj_valid);
endmodule

bind ecc_inject_ctrl eci_checker #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .TAG_W(TAG_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr_en (reg_wr_en),
    .reg_waddr (reg_waddr),
    .acc_valid (acc_valid),
    .inj_ack   (inj_ack),
    .inj_valid (inj_valid),
    .inj_target(inj_target),
    .inj_bank  (inj_bank),
    .inj_mask  (inj_mask),
    .en_q      (en_q),
    .pers_q    (pers_q),
    .dlyen_q   (dlyen_q),
    .count     (count),
    .reload_val(reload_val)
);

// File: tb/ecc_inject_ctrl_tb.sv
module ecc_inject_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 8;
    localparam int TW = 24;
    localparam logic [63:0] M = 64'hF0F0_0000_12AB_CDEF;
    localparam logic [63:0] M_TAG = 64'h0000_0000_00AB_CDEF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_wr_en = 1'b0;
    logic [6:0] reg_waddr = '0;
    logic [63:0] reg_wdata = '0;
    logic [6:0] reg_raddr = '0;
    logic [63:0] reg_rdata;
    logic acc_valid = 1'b0;
    logic inj_ack = 1'b0;
    logic inj_valid, inj_target;
    logic [NB-1:0] inj_bank;
    logic [63:0] inj_mask;

    int vectors = 0;
    int miscompares = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_inject_ctrl #(.ADDR_W(7), .NUM_BANKS(NB), .TAG_W(TW)) u_dut (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
        .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .acc_valid(acc_valid), .inj_ack(inj_ack),
        .inj_valid(inj_valid), .inj_target(inj_target),
        .inj_bank(inj_bank), .inj_mask(inj_mask)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic        wr;
        logic [6:0]  waddr;
        logic [63:0] wdata;
        logic        acc;
        logic        ack;
        logic [6:0]  raddr;
        logic [63:0] exp_rd;
        logic        exp_inj;
    } vec_t;

    localparam int NV = 18;
    // Each row: inputs for one cycle; expectations are the outputs before
    // that cycle's rising edge.
    localparam vec_t VECS [NV] = '{
        '{8'd2,  1'b1, 7'd16, M,         1'b0, 1'b0, 7'd0,  64'd0,     1'b0}, // R2 mask write
        '{8'd2,  1'b1, 7'd8,  64'd3,     1'b0, 1'b0, 7'd16, M,         1'b0}, // R2 delay write
        '{8'd11, 1'b1, 7'd0,  64'hA57,   1'b1, 1'b0, 7'd8,  64'd3,     1'b0}, // R11 still off
        '{8'd4,  1'b0, 7'd0,  64'd0,     1'b1, 1'b0, 7'd0,  64'hA57,   1'b0}, // R4 armed delayed
        '{8'd4,  1'b0, 7'd0,  64'd0,     1'b1, 1'b0, 7'd8,  64'd2,     1'b0}, // R4
        '{8'd4,  1'b0, 7'd0,  64'd0,     1'b1, 1'b0, 7'd8,  64'd1,     1'b0}, // R4
        '{8'd9,  1'b0, 7'd0,  64'd0,     1'b1, 1'b0, 7'd8,  64'd0,     1'b1}, // R9 strobe, no ack
        '{8'd9,  1'b0, 7'd0,  64'd0,     1'b1, 1'b1, 7'd8,  64'd0,     1'b1}, // R9 still armed
        '{8'd6,  1'b0, 7'd0,  64'd0,     1'b1, 1'b0, 7'd8,  64'd3,     1'b0}, // R6 reloaded
        '{8'd10, 1'b1, 7'd8,  64'd5,     1'b0, 1'b0, 7'd8,  64'd2,     1'b0}, // R10 rewrite
        '{8'd10, 1'b0, 7'd0,  64'd0,     1'b0, 1'b0, 7'd8,  64'd5,     1'b0}, // R10 restarted
        '{8'd4,  1'b1, 7'd0,  64'h39,    1'b0, 1'b0, 7'd8,  64'd4,     1'b0}, // R4 counting
        '{8'd3,  1'b0, 7'd0,  64'd0,     1'b1, 1'b1, 7'd0,  64'h39,    1'b1}, // R3 immediate
        '{8'd5,  1'b0, 7'd0,  64'd0,     1'b1, 1'b0, 7'd0,  64'h38,    1'b0}, // R5 one-shot
        '{8'd2,  1'b1, 7'd24, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 7'd16, M, 1'b0}, // R2 unmapped
        '{8'd2,  1'b0, 7'd0,  64'd0,     1'b0, 1'b0, 7'd24, 64'd0,     1'b0}, // R2 reads 0
        '{8'd2,  1'b1, 7'd0,  64'hFFFF_FFFF_FFFF_F000, 1'b0, 1'b0, 7'd16, M, 1'b0}, // R2
        '{8'd2,  1'b0, 7'd0,  64'd0,     1'b0, 1'b0, 7'd0,  64'd0,     1'b0}  // R2 undefined bits
    };

    task automatic check64(input string req, input string what,
                           input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic [6:0] wa, input logic [63:0] wd,
                         input logic acc, input logic ack, input logic [6:0] ra);
        @(negedge clk);
        reg_wr_en = wr; reg_waddr = wa; reg_wdata = wd;
        acc_valid = acc; inj_ack = ack; reg_raddr = ra;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        miscompares++;
        vectors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1: reset state, access present during reset
        drive(1'b0, 7'd0, 64'd0, 1'b1, 1'b0, 7'd0);
        check64("R1", "inj_valid in reset", {63'd0, inj_valid}, 64'd0);
        rst = 1'b0;
        drive(1'b0, 7'd0, 64'd0, 1'b1, 1'b0, 7'd0);
        check64("R1", "ctrl after reset", reg_rdata, 64'd0);
        check64("R1", "inj_valid after reset", {63'd0, inj_valid}, 64'd0);
        drive(1'b0, 7'd0, 64'd0, 1'b1, 1'b0, 7'd8);
        check64("R1", "delay after reset", reg_rdata, 64'd0);
        drive(1'b0, 7'd0, 64'd0, 1'b1, 1'b0, 7'd16);
        check64("R1", "mask after reset", reg_rdata, 64'd0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].wr, VECS[i].waddr, VECS[i].wdata,
                  VECS[i].acc, VECS[i].ack, VECS[i].raddr);
            check64($sformatf("R%0d row %0d", VECS[i].req, i), "rdata",
                    reg_rdata, VECS[i].exp_rd);
            check64($sformatf("R%0d row %0d", VECS[i].req, i), "inj_valid",
                    {63'd0, inj_valid}, {63'd0, VECS[i].exp_inj});
        end

        // R7 / R8: tag target trims mask, bank passes through
        drive(1'b1, 7'd16, M, 1'b0, 1'b0, 7'd0);
        drive(1'b1, 7'd0, 64'hA51, 1'b0, 1'b0, 7'd0);
        drive(1'b0, 7'd0, 64'd0, 1'b1, 1'b0, 7'd0);
        check64("R3", "tag strobe", {63'd0, inj_valid}, 64'd1);
        check64("R7", "tag target", {63'd0, inj_target}, 64'd0);
        check64("R7", "tag mask", inj_mask, M_TAG);
        check64("R8", "bank", {56'd0, inj_bank}, 64'hA5);
        // R11: outputs quiet without access
        drive(1'b0, 7'd0, 64'd0, 1'b0, 1'b0, 7'd0);
        check64("R11", "mask idle", inj_mask, 64'd0);
        check64("R11", "bank idle", {56'd0, inj_bank}, 64'd0);
        // R7 data target uses the full mask
        drive(1'b1, 7'd0, 64'h3C9, 1'b0, 1'b0, 7'd0);
        drive(1'b0, 7'd0, 64'd0, 1'b1, 1'b0, 7'd0);
        check64("R7", "data target", {63'd0, inj_target}, 64'd1);
        check64("R7", "data mask", inj_mask, M);
        check64("R8", "bank data", {56'd0, inj_bank}, 64'h3C);
        // R6: persistent immediate injection survives an ack
        drive(1'b1, 7'd0, 64'h3, 1'b0, 1'b0, 7'd0);
        drive(1'b0, 7'd0, 64'd0, 1'b1, 1'b1, 7'd0);
        check64("R6", "persist strobe", {63'd0, inj_valid}, 64'd1);
        drive(1'b0, 7'd0, 64'd0, 1'b1, 1'b0, 7'd0);
        check64("R6", "persist ctrl kept", reg_rdata, 64'h3);
        check64("R6", "persist strobe again", {63'd0, inj_valid}, 64'd1);
        // R5: one-shot immediate, then nothing
        drive(1'b1, 7'd0, 64'h1, 1'b0, 1'b0, 7'd0);
        drive(1'b0, 7'd0, 64'd0, 1'b1, 1'b1, 7'd0);
        check64("R5", "one-shot strobe", {63'd0, inj_valid}, 64'd1);
        drive(1'b0, 7'd0, 64'd0, 1'b1, 1'b0, 7'd0);
        check64("R5", "enable cleared", reg_rdata, 64'd0);
        check64("R5", "no second strobe", {63'd0, inj_valid}, 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule